// File: doc/BRIEF.md
# Selectable Parallel Display Bus Master

This block is the host-side engine that moves one byte at a time between a system and a display controller over an 8-bit parallel bus. The user side asks for a transfer with a valid pulse, a read/write flag, a data/command flag and a write byte. The block runs the whole bus cycle. When the cycle is over it gives back a one-cycle done pulse and, for reads, the captured byte.

Two bus styles are selectable through a static two-bit mode input. The first uses an enable strobe that latches on its falling edge, together with a read/write level. The second uses separate active-low read and write strobes that latch on their rising edges. A further variant of the second style keeps the read or write strobe steady and uses the rising edge of chip select as the latch. Setup, strobe and hold widths are parameters counted in system clocks. The data bus is brought out as separate out, in and output-enable signals so that a pad cell can be placed above this block. Mode codes that select a serial or two-wire style are refused, because those styles belong to other engines.

Top module: `pbus_master`

## Requirements
- R1: After reset, and while idle, chip select is high, the output enable is low, and done and error are low. The read/write pin is high. The enable/read pin is low in mode 2'b10 and high in mode 2'b11.
- R2: In mode 2'b10 (enable style), a write holds chip select low for SETUP_CYC+STROBE_CYC+HOLD_CYC cycles with the read/write pin low throughout. The enable pin is high for exactly STROBE_CYC cycles, all of them inside the chip-select window.
- R3: In mode 2'b10, a read holds the read/write pin high while chip select is low. The byte returned on rdata_o is the value present on the input bus during the last cycle of the enable pulse.
- R4: The data/command pin equals the request's dc flag (0 for command, 1 for data) for the whole active window and does not change inside it.
- R5: In mode 2'b11 with cs_latch_i low, a write drives the write-strobe pin low for exactly STROBE_CYC cycles inside a chip-select window of SETUP_CYC+STROBE_CYC+HOLD_CYC cycles. The read-strobe pin stays high.
- R6: In mode 2'b11 with cs_latch_i low, a read drives the read-strobe pin low for exactly STROBE_CYC cycles while the write-strobe pin stays high. rdata_o returns the bus value from the last strobe cycle.
- R7: In mode 2'b11 with cs_latch_i high, the selected read or write strobe is held low for SETUP_CYC+STROBE_CYC+HOLD_CYC cycles. Chip select goes low only for the STROBE_CYC cycles in the middle of that window.
- R8: The active strobe asserts exactly SETUP_CYC cycles after the window opens. The window stays open HOLD_CYC cycles after the strobe ends.
- R9: A write drives the output enable high over the entire active window with the request byte on bus_d_o. A read never raises the output enable.
- R10: A request made while the mode is 2'b00 or 2'b01 gets done_o and err_o together in the cycle after acceptance. Chip select stays high.
- R11: done_o is a single-cycle pulse one cycle after the hold count expires. A request presented while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bus style: 10 enable style, 11 separate strobes, 00/01 refused |
| cs_latch_i | input | 1 | In mode 11, chip select acts as the latch strobe |
| req_valid_i | input | 1 | Request pulse, taken only when idle |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_dc_i | input | 1 | 0 = command/status, 1 = data |
| req_wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Byte captured by the last read |
| done_o | output | 1 | Transfer finished (one cycle) |
| err_o | output | 1 | Request refused, valid with done_o |
| bus_d_o | output | 8 | Data bus output value |
| bus_d_i | input | 8 | Data bus input value |
| bus_oe_o | output | 1 | Data bus output enable |
| bus_dc_o | output | 1 | Data/command pin |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_rw_wrn_o | output | 1 | Read/write level (mode 10) or write strobe, active low (mode 11) |
| bus_e_rdn_o | output | 1 | Enable strobe (mode 10) or read strobe, active low (mode 11) |

## Verification
Each bus style is exercised with both a write and a read, and with both command and data flags. Comparing them shows whether the correct strobe pin moves, whether the read/write level and the output enable follow the direction, and whether the data/command level follows the request. During reads the input bus takes a new value in every strobe cycle, so a capture one cycle early or late returns the wrong byte. The chip-select-latch variant is checked against the normal separate-strobe run, which separates the two window shapes. Refused mode codes and a request injected mid-transfer show that no bus cycle starts when none should.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } pbus_st_e;

  typedef enum logic [1:0] {
    BUS_SER = 2'b00,
    BUS_TWI = 2'b01,
    BUS_M68 = 2'b10,
    BUS_I80 = 2'b11
  } pbus_mode_e;

  function automatic logic mode_is_parallel(logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/pbus_timer.sv
module pbus_timer #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 4,
  parameter int HOLD_CYC   = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_valid_i,
  input  logic     par_ok_i,
  output pbus_st_e state_o,
  output logic     accept_o,
  output logic     capture_o,
  output logic     done_o,
  output logic     err_o
);
  localparam int MAXC = (SETUP_CYC > STROBE_CYC)
                        ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                        : ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] S_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] T_LD = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] H_LD = CW'(HOLD_CYC - 1);

  pbus_st_e      st_q, st_d;
  logic          err_q, err_d;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          zero;

  pbus_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .zero_o (zero)
  );

  always_comb begin
    st_d   = st_q;
    err_d  = err_q;
    ld     = 1'b0;
    ld_val = S_LD;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        if (par_ok_i) begin
          st_d   = ST_SETUP;
          ld     = 1'b1;
          ld_val = S_LD;
          err_d  = 1'b0;
        end else begin
          st_d  = ST_DONE;
          err_d = 1'b1;
        end
      end
      ST_SETUP: if (zero) begin
        st_d   = ST_STROBE;
        ld     = 1'b1;
        ld_val = T_LD;
      end
      ST_STROBE: if (zero) begin
        st_d   = ST_HOLD;
        ld     = 1'b1;
        ld_val = H_LD;
      end
      ST_HOLD:  if (zero) st_d = ST_DONE;
      ST_DONE: begin
        st_d  = ST_IDLE;
        err_d = 1'b0;
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign state_o   = st_q;
  assign accept_o  = (st_q == ST_IDLE) && req_valid_i && par_ok_i;
  assign capture_o = (st_q == ST_STROBE) && zero;
  assign done_o    = (st_q == ST_DONE);
  assign err_o     = (st_q == ST_DONE) && err_q;
endmodule

// File: rtl/pbus_pins.sv
module pbus_pins
  import pbus_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       cs_latch_i,
  input  pbus_st_e   state_i,
  input  logic       rd_i,
  input  logic       dc_i,
  output logic       cs_no,
  output logic       pin_a_o,
  output logic       pin_b_o,
  output logic       dc_o,
  output logic       oe_o
);
  logic win, stb;

  assign win = (state_i == ST_SETUP) || (state_i == ST_STROBE) || (state_i == ST_HOLD);
  assign stb = (state_i == ST_STROBE);

  always_comb begin
    dc_o = win ? dc_i : 1'b0;
    oe_o = win && !rd_i;
    if (mode_i == BUS_I80) begin
      if (cs_latch_i) begin
        // strobes held through window, chip select is the latch
        cs_no   = !stb;
        pin_a_o = !(win && !rd_i);
        pin_b_o = !(win && rd_i);
      end else begin
        cs_no   = !win;
        pin_a_o = !(stb && !rd_i);
        pin_b_o = !(stb && rd_i);
      end
    end else begin
      cs_no   = !win;
      pin_a_o = win ? rd_i : 1'b1;
      pin_b_o = stb;
    end
  end
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 4,
  parameter int HOLD_CYC   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          cs_latch_i,
  input  logic          req_valid_i,
  input  logic          req_rd_i,
  input  logic          req_dc_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] bus_d_o,
  input  logic [DW-1:0] bus_d_i,
  output logic          bus_oe_o,
  output logic          bus_dc_o,
  output logic          bus_cs_no,
  output logic          bus_rw_wrn_o,
  output logic          bus_e_rdn_o
);
  pbus_st_e      state;
  logic          accept, capture;
  logic          rd_q, dc_q;
  logic [DW-1:0] wdata_q, rdata_q;

  pbus_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .par_ok_i    (mode_is_parallel(mode_i)),
    .state_o     (state),
    .accept_o    (accept),
    .capture_o   (capture),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      dc_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        rd_q    <= req_rd_i;
        dc_q    <= req_dc_i;
        wdata_q <= req_wdata_i;
      end
      if (capture && rd_q) rdata_q <= bus_d_i;
    end
  end

  pbus_pins u_pins (
    .mode_i     (mode_i),
    .cs_latch_i (cs_latch_i),
    .state_i    (state),
    .rd_i       (rd_q),
    .dc_i       (dc_q),
    .cs_no      (bus_cs_no),
    .pin_a_o    (bus_rw_wrn_o),
    .pin_b_o    (bus_e_rdn_o),
    .dc_o       (bus_dc_o),
    .oe_o       (bus_oe_o)
  );

  assign bus_d_o = wdata_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       cs_latch_i,
  input logic       done_o,
  input logic       err_o,
  input logic       bus_oe_o,
  input logic       bus_dc_o,
  input logic       bus_cs_no,
  input logic       bus_rw_wrn_o,
  input logic       bus_e_rdn_o
);
  // R2
  m68_stb_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && bus_e_rdn_o) |-> !bus_cs_no);

  // R8
  m68_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(mode_i) && mode_i == 2'b10 && $rose(bus_e_rdn_o)) |-> $past(!bus_cs_no));

  // R5
  i80_wr_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !cs_latch_i && !bus_rw_wrn_o) |-> !bus_cs_no);

  // R9
  rd_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !bus_e_rdn_o) |-> !bus_oe_o);

  // R4
  dc_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no && $past(!bus_cs_no)) |-> $stable(bus_dc_o));

  // R11
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && bus_cs_no));
endmodule

bind pbus_master pbus_master_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .cs_latch_i   (cs_latch_i),
  .done_o       (done_o),
  .err_o        (err_o),
  .bus_oe_o     (bus_oe_o),
  .bus_dc_o     (bus_dc_o),
  .bus_cs_no    (bus_cs_no),
  .bus_rw_wrn_o (bus_rw_wrn_o),
  .bus_e_rdn_o  (bus_e_rdn_o)
);

// File: tb/pbus_master_bench.sv
module pbus_master_bench;
  localparam int S = 2, T = 4, H = 2;
  localparam int WIN = S + T + H;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b10;
  logic       cs_latch_i = 1'b0;
  logic       req_valid_i = 1'b0, req_rd_i = 1'b0, req_dc_i = 1'b0;
  logic [7:0] req_wdata_i = '0, bus_d_i = '0;
  logic [7:0] rdata_o, bus_d_o;
  logic       done_o, err_o, bus_oe_o, bus_dc_o, bus_cs_no, bus_rw_wrn_o, bus_e_rdn_o;

  always #2 clk_i = ~clk_i;

  pbus_master #(.DW(8), .SETUP_CYC(S), .STROBE_CYC(T), .HOLD_CYC(H)) u_pbus_master (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int n_cyc, n_win, n_cs, n_stb, n_oth, first_stb, n_oe, dc_bad, rw_bad, dat_bad, err_seen;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one request and gathers pin statistics until done_o
  task automatic xfer(input bit rd, input bit dc, input logic [7:0] val, input bit inject);
    int k;
    bit cs_low, stb, oth, win;
    n_cyc = 0; n_win = 0; n_cs = 0; n_stb = 0; n_oth = 0; first_stb = -1;
    n_oe = 0; dc_bad = 0; rw_bad = 0; dat_bad = 0; err_seen = 0; k = 0;
    @(negedge clk_i);
    req_valid_i = 1; req_rd_i = rd; req_dc_i = dc; req_wdata_i = val;
    @(negedge clk_i);
    req_valid_i = 0;
    while (!done_o && n_cyc < 100) begin
      cs_low = !bus_cs_no;
      if (mode_i == 2'b10) begin
        stb = bus_e_rdn_o; oth = 0; win = cs_low;
        if (cs_low && bus_rw_wrn_o != rd) rw_bad++;
      end else if (cs_latch_i) begin
        stb = cs_low;
        win = rd ? !bus_e_rdn_o : !bus_rw_wrn_o;
        oth = rd ? !bus_rw_wrn_o : !bus_e_rdn_o;
      end else begin
        stb = rd ? !bus_e_rdn_o : !bus_rw_wrn_o;
        oth = rd ? !bus_rw_wrn_o : !bus_e_rdn_o;
        win = cs_low;
      end
      if (cs_low) n_cs++;
      if (win) begin
        n_win++;
        if (bus_dc_o != dc) dc_bad++;
      end
      if (oth) n_oth++;
      if (stb) begin
        if (first_stb < 0) first_stb = n_cyc;
        n_stb++;
        k++;
        bus_d_i = val + 8'(k);
      end else bus_d_i = ~val;
      if (bus_oe_o) begin
        n_oe++;
        if (bus_d_o != val) dat_bad++;
      end
      if (inject) begin
        req_valid_i = (n_cyc == 3);
        req_rd_i = ~rd; req_wdata_i = ~val;
      end
      n_cyc++;
      @(negedge clk_i);
    end
    req_valid_i = 0;
    err_seen = err_o;
  endtask

  task automatic t_reset;
    chk(bus_cs_no && !bus_oe_o && !done_o && !err_o && bus_rw_wrn_o && !bus_e_rdn_o,
        "R1 idle pins m68", {bus_cs_no, bus_oe_o, done_o, err_o}, 4'b1000);
    mode_i = 2'b11;
    @(negedge clk_i);
    chk(bus_e_rdn_o && bus_rw_wrn_o && bus_cs_no, "R1 idle pins i80", bus_e_rdn_o, 1);
    mode_i = 2'b10;
  endtask

  task automatic t_m68_write;
    mode_i = 2'b10; cs_latch_i = 0;
    xfer(0, 1, 8'hA5, 0);
    chk(n_cs == WIN, "R2 cs window", n_cs, WIN);
    chk(n_stb == T, "R2 enable width", n_stb, T);
    chk(rw_bad == 0, "R2 rw level", rw_bad, 0);
    chk(first_stb == S, "R8 setup", first_stb, S);
    chk(n_oe == WIN && dat_bad == 0, "R9 write drive", n_oe, WIN);
    chk(dc_bad == 0, "R4 dc data", dc_bad, 0);
    chk(n_cyc == WIN && !err_seen, "R11 done timing", n_cyc, WIN);
  endtask

  task automatic t_m68_read;
    mode_i = 2'b10; cs_latch_i = 0;
    xfer(1, 0, 8'h30, 0);
    chk(rw_bad == 0, "R3 rw high", rw_bad, 0);
    chk(rdata_o == 8'h30 + T, "R3 read capture", rdata_o, 8'h30 + T);
    chk(n_oe == 0, "R9 read no drive", n_oe, 0);
    chk(dc_bad == 0, "R4 dc command", dc_bad, 0);
  endtask

  task automatic t_i80_write;
    mode_i = 2'b11; cs_latch_i = 0;
    xfer(0, 0, 8'h3C, 0);
    chk(n_cs == WIN && n_stb == T, "R5 wr strobe", n_stb, T);
    chk(n_oth == 0, "R5 rd idle", n_oth, 0);
    chk(first_stb == S && n_cyc == WIN, "R8 setup/hold i80", first_stb, S);
    chk(n_oe == WIN && dat_bad == 0, "R9 write drive i80", dat_bad, 0);
  endtask

  task automatic t_i80_read;
    mode_i = 2'b11; cs_latch_i = 0;
    xfer(1, 1, 8'h51, 0);
    chk(n_stb == T && n_oth == 0, "R6 rd strobe", n_stb, T);
    chk(rdata_o == 8'h51 + T, "R6 read capture", rdata_o, 8'h51 + T);
    chk(dc_bad == 0 && n_oe == 0, "R4 dc data read", dc_bad, 0);
  endtask

  task automatic t_cs_latch;
    mode_i = 2'b11; cs_latch_i = 1;
    xfer(0, 1, 8'hC3, 0);
    chk(n_win == WIN && n_cs == T, "R7 write held strobe", n_cs, T);
    chk(first_stb == S && n_oth == 0, "R7 cs latch position", first_stb, S);
    xfer(1, 0, 8'h10, 0);
    chk(n_win == WIN && n_cs == T, "R7 read held strobe", n_win, WIN);
    chk(rdata_o == 8'h10 + T, "R7 read capture", rdata_o, 8'h10 + T);
    cs_latch_i = 0;
  endtask

  task automatic t_refuse;
    mode_i = 2'b00;
    xfer(1, 0, 8'h22, 0);
    chk(n_cyc == 0 && err_seen == 1, "R10 serial refused", n_cyc, 0);
    chk(n_cs == 0, "R10 no cs", n_cs, 0);
    mode_i = 2'b01;
    xfer(0, 1, 8'h22, 0);
    chk(n_cyc == 0 && err_seen == 1 && n_cs == 0, "R10 two-wire refused", err_seen, 1);
    mode_i = 2'b10;
  endtask

  task automatic t_busy;
    int extra;
    mode_i = 2'b10;
    xfer(0, 0, 8'h66, 1);
    chk(n_cyc == WIN && dat_bad == 0 && rw_bad == 0, "R11 busy request ignored", dat_bad, 0);
    extra = 0;
    repeat (WIN + 2) begin
      @(negedge clk_i);
      if (!bus_cs_no || done_o) extra++;
    end
    chk(extra == 0, "R11 no second transfer", extra, 0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(bus_cs_no && !bus_oe_o, "R1 in reset", bus_cs_no, 1);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_m68_write();
    t_m68_read();
    t_i80_write();
    t_i80_read();
    t_cs_latch();
    t_refuse();
    t_busy();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule